// File: doc/BRIEF.md
# Extended PRG and RAM Bank Decoder

Some cartridge boards built around a serially loaded bank-switching mapper take the upper lines of the character-ROM bank outputs and route them to program memory instead. This block sits after the two character bank registers. It picks the bank value that the current picture-fetch half is using. Depending on the board size, it turns bits of that value into an extra program-ROM address line (A18, which picks one 256 KiB half of a 512 KiB ROM), a two-bit page select for the 8 KiB work-RAM window at 0x6000-0x7FFF, and a work-RAM enable.

Two static board flags describe the board: large PRG ROM (512 KiB) and small CHR (8 KiB ROM or CHR RAM). They are captured only while reset is asserted, and the result is held in a four-state board register:
- `BRD_PLAIN`: small PRG, large CHR. No side effects.
- `BRD_ROMEXT`: large PRG, large CHR. Block select only.
- `BRD_ROMEXT_RAMPG`: large PRG, small CHR. Block select and RAM paging.
- `BRD_RAMPG_GATE`: small PRG, small CHR. RAM paging, and bit 4 gates the RAM.

The only transition is a reload. Every clock edge with reset high moves the register to the state the flags select. Every edge with reset low holds the current state. The outputs are a combinational function of the state and the live inputs, so they follow each picture fetch in the same cycle.

Top module: `xbank_decoder`

## Requirements
- R1: The board flags take effect only at clock edges while `rst` is high. Changing them while `rst` is low leaves every output unchanged.
- R2: With the large-PRG flag captured, `prg_a18` equals bit 4 of the active bank value in the same cycle. This applies to every PRG access, fixed pages included. With small PRG, `prg_a18` is 0.
- R3: With `chr_4k`=0 (8 KiB CHR mode), the active bank value is `chr_bank0`. `chr_bank1` and `ppu_a12` have no effect on any output.
- R4: With `chr_4k`=1 (4 KiB mode), the active bank value is `chr_bank0` while `ppu_a12`=0 and `chr_bank1` while `ppu_a12`=1.
- R5: With the small-CHR flag captured, `ram_page` equals bits 3:2 of the active bank value. Bit 3 is the page MSB.
- R6: With large CHR, `ram_page` is 0 and `ram_en` is the inverse of `wram_dis`. The CHR bank values have no effect on the RAM outputs.
- R7: With both small PRG and small CHR, an active bank bit 4 of 1 forces `ram_en` to 0.
- R8: `wram_dis`=1 forces `ram_en` to 0 on every board.
- R9: With large PRG and small CHR, bit 4 drives `prg_a18` only and does not gate the RAM.
- R10: After reset, with zero bank values and `wram_dis`=0, the outputs are `prg_a18`=0, `ram_page`=0 and `ram_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; board flags are captured while high |
| cfg_large_prg | input | 1 | Board has 512 KiB PRG ROM |
| cfg_small_chr | input | 1 | Board has 8 KiB CHR ROM or CHR RAM |
| chr_4k | input | 1 | CHR mode: 1 = two 4 KiB banks, 0 = one 8 KiB bank |
| ppu_a12 | input | 1 | Picture-fetch half select (high half when 1) |
| chr_bank0 | input | 5 | First CHR bank register value |
| chr_bank1 | input | 5 | Second CHR bank register value |
| wram_dis | input | 1 | Work-RAM disable bit from the PRG bank register |
| prg_a18 | output | 1 | PRG ROM 256 KiB block select |
| ram_page | output | 2 | Work-RAM 8 KiB page select |
| ram_en | output | 1 | Work-RAM enable |

## Verification
The bench aims at the places where the bank source changes: `ppu_a12` toggling in 4 KiB mode must move all three outputs, while the same toggling in 8 KiB mode must move none. A design that muxed without regard to the mode would show page or block changes driven by `chr_bank1`. Board flags are flipped after reset to catch a design that decodes them live rather than from the captured state. Bit 4 is driven high on each of the four boards. A design that gated the RAM on the large-PRG small-CHR board would lose `ram_en`, and one that forgot the gate on the small board would keep it.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
    parameter int BANK_W    = 5;
    parameter int PAGE_W    = 2;
    parameter int BLOCK_BIT = 4;
    parameter int PAGE_LSB  = 2;
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

    typedef enum logic [1:0] {
        BRD_PLAIN        = 2'd0,
        BRD_ROMEXT       = 2'd1,
        BRD_ROMEXT_RAMPG = 2'd2,
        BRD_RAMPG_GATE   = 2'd3
    } board_e;
endpackage

// File: rtl/xbank_board_fsm.sv
module xbank_board_fsm
    import xbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_large_prg,
    input  logic   cfg_small_chr,
    output board_e board
);
    board_e board_q;
    board_e board_load;

    // Decode the flags into the state that a reset would load.
    always_comb begin
        unique case ({cfg_large_prg, cfg_small_chr})
            2'b00:   board_load = BRD_PLAIN;
            2'b10:   board_load = BRD_ROMEXT;
            2'b11:   board_load = BRD_ROMEXT_RAMPG;
            default: board_load = BRD_RAMPG_GATE;
        endcase
    end

    // State register: reload while in reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (rst) board_q <= board_load;
        else     board_q <= board_q;
    end

    assign board = board_q;
endmodule

// File: rtl/xbank_src_sel.sv
module xbank_src_sel
    import xbank_pkg::*;
(
    input  logic              chr_4k,
    input  logic              ppu_a12,
    input  logic [BANK_W-1:0] chr_bank0,
    input  logic [BANK_W-1:0] chr_bank1,
    output logic [BANK_W-1:0] act_bank
);
    // 8 KiB mode ignores the second register and the fetch half.
    always_comb begin
        if (chr_4k && ppu_a12) act_bank = chr_bank1;
        else                   act_bank = chr_bank0;
    end
endmodule

// File: rtl/xbank_decode.sv
module xbank_decode
    import xbank_pkg::*;
(
    input  board_e            board,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              wram_dis,
    output logic              prg_a18,
    output logic [PAGE_W-1:0] ram_page,
    output logic              ram_en
);
    logic              blk_bit;
    logic [PAGE_W-1:0] pg_bits;

    assign blk_bit = act_bank[BLOCK_BIT];
    assign pg_bits = act_bank[PAGE_MSB:PAGE_LSB];

    always_comb begin
        unique case (board)
            BRD_PLAIN: begin
                prg_a18  = 1'b0;
                ram_page = '0;
                ram_en   = !wram_dis;
            end
            BRD_ROMEXT: begin
                prg_a18  = blk_bit;
                ram_page = '0;
                ram_en   = !wram_dis;
            end
            BRD_ROMEXT_RAMPG: begin
                prg_a18  = blk_bit;
                ram_page = pg_bits;
                ram_en   = !wram_dis;
            end
            default: begin
                prg_a18  = 1'b0;
                ram_page = pg_bits;
                ram_en   = !(wram_dis || blk_bit);
            end
        endcase
    end
endmodule

// File: rtl/xbank_decoder.sv
module xbank_decoder
    import xbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_large_prg,
    input  logic              cfg_small_chr,
    input  logic              chr_4k,
    input  logic              ppu_a12,
    input  logic [BANK_W-1:0] chr_bank0,
    input  logic [BANK_W-1:0] chr_bank1,
    input  logic              wram_dis,
    output logic              prg_a18,
    output logic [PAGE_W-1:0] ram_page,
    output logic              ram_en
);
    board_e            board;
    logic [BANK_W-1:0] act_bank;

    xbank_board_fsm u_fsm (
        .clk(clk), .rst(rst),
        .cfg_large_prg(cfg_large_prg), .cfg_small_chr(cfg_small_chr),
        .board(board)
    );

    xbank_src_sel u_sel (
        .chr_4k(chr_4k), .ppu_a12(ppu_a12),
        .chr_bank0(chr_bank0), .chr_bank1(chr_bank1),
        .act_bank(act_bank)
    );

    xbank_decode u_dec (
        .board(board), .act_bank(act_bank), .wram_dis(wram_dis),
        .prg_a18(prg_a18), .ram_page(ram_page), .ram_en(ram_en)
    );
endmodule

// File: rtl/xbank_decoder_chk.sv
module xbank_decoder_chk
    import xbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_large_prg,
    input logic              cfg_small_chr,
    input logic              chr_4k,
    input logic              ppu_a12,
    input logic [BANK_W-1:0] chr_bank0,
    input logic [BANK_W-1:0] chr_bank1,
    input logic              wram_dis,
    input logic              prg_a18,
    input logic [PAGE_W-1:0] ram_page,
    input logic              ram_en
);
    logic lp_q, sc_q, armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q    <= cfg_large_prg;
            sc_q    <= cfg_small_chr;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R1
    cfg_ignored_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($stable(chr_4k) && $stable(ppu_a12) && $stable(chr_bank0) &&
         $stable(chr_bank1) && $stable(wram_dis))
        |-> ($stable(prg_a18) && $stable(ram_page) && $stable(ram_en)));

    // R2
    small_prg_no_block_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !lp_q |-> !prg_a18);

    // R3
    eight_k_ignores_half_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!chr_4k && !$past(chr_4k) && $stable(chr_bank0) && $stable(wram_dis))
        |-> ($stable(prg_a18) && $stable(ram_page) && $stable(ram_en)));

    // R6
    large_chr_no_page_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !sc_q |-> (ram_page == '0));

    // R7
    small_board_gate_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!lp_q && sc_q && !chr_4k && chr_bank0[BLOCK_BIT]) |-> !ram_en);

    // R8
    wram_dis_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        wram_dis |-> !ram_en);
endmodule

bind xbank_decoder xbank_decoder_chk u_chk (.*);

// File: tb/xbank_decoder_test.sv
module xbank_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_large_prg = 1'b0, cfg_small_chr = 1'b0;
    logic       chr_4k = 1'b0, ppu_a12 = 1'b0, wram_dis = 1'b0;
    logic [4:0] chr_bank0 = '0, chr_bank1 = '0;
    logic       prg_a18, ram_en;
    logic [1:0] ram_page;

    int checks = 0;
    int errors = 0;
    bit m_lp, m_sc;   // model's captured board flags

    always #4 clk = ~clk;

    xbank_decoder uut (.*);

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference for the current inputs.
    task automatic compare_all();
        int src, e_a18, e_pg, e_en;
        src   = (chr_4k && ppu_a12) ? int'(chr_bank1) : int'(chr_bank0);
        e_a18 = m_lp ? (src / 16) % 2 : 0;
        e_pg  = m_sc ? (src / 4) % 4 : 0;
        e_en  = 1;
        if (wram_dis) e_en = 0;
        if (!m_lp && m_sc && ((src / 16) % 2 == 1)) e_en = 0;
        chk(m_lp ? "R2 block" : "R2 small", int'(prg_a18), e_a18);
        chk(m_sc ? "R5 page" : "R6 page", int'(ram_page), e_pg);
        chk(wram_dis ? "R8 disable" : (m_lp ? "R9 enable" : "R7 gate"),
            int'(ram_en), e_en);
    endtask

    task automatic do_reset(bit lp, bit sc);
        @(posedge clk); #1;
        rst = 1'b1; cfg_large_prg = lp; cfg_small_chr = sc;
        chr_4k = 0; ppu_a12 = 0; chr_bank0 = 0; chr_bank1 = 0; wram_dis = 0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0; m_lp = lp; m_sc = sc;
        @(negedge clk);
        // R10 reset state
        chk("R10 a18", int'(prg_a18), 0);
        chk("R10 page", int'(ram_page), 0);
        chk("R10 en", int'(ram_en), 1);
    endtask

    task automatic step(bit m4k, bit a12, logic [4:0] b0, logic [4:0] b1, bit wd);
        @(posedge clk); #1;
        chr_4k = m4k; ppu_a12 = a12; chr_bank0 = b0; chr_bank1 = b1; wram_dis = wd;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            bit lp, sc;
            lp = cfg[1]; sc = cfg[0];
            do_reset(lp, sc);

            // R3: 8 KiB mode, half toggles, bank1 changes: outputs follow bank0
            step(0, 0, 5'b11100, 5'b00000, 0);
            step(0, 1, 5'b11100, 5'b01000, 0);
            chk("R3 a18", int'(prg_a18), lp ? 1 : 0);
            chk("R3 page", int'(ram_page), sc ? 3 : 0);

            // R4: 4 KiB mode, halves differ
            step(1, 0, 5'b00100, 5'b11000, 0);
            chk("R4 low a18", int'(prg_a18), 0);
            chk("R4 low page", int'(ram_page), sc ? 1 : 0);
            step(1, 1, 5'b00100, 5'b11000, 0);
            chk("R4 high a18", int'(prg_a18), lp ? 1 : 0);
            chk("R4 high page", int'(ram_page), sc ? 2 : 0);
            chk("R4 high en", int'(ram_en), (!lp && sc) ? 0 : 1);

            // R7 / R9: bit 4 set with RAM otherwise enabled
            step(0, 0, 5'b10000, 5'b00000, 0);
            chk(lp ? "R9 no gate" : "R7 gate", int'(ram_en), (!lp && sc) ? 0 : 1);

            // R8: disable bit
            step(0, 0, 5'b00000, 5'b00000, 1);
            chk("R8 disable", int'(ram_en), 0);

            // R6: large CHR, bank bits have no RAM effect
            step(0, 0, 5'b01100, 5'b01100, 0);
            if (!sc) chk("R6 page", int'(ram_page), 0);

            // R1: flip flags after reset, outputs unchanged
            @(posedge clk); #1;
            cfg_large_prg = !lp; cfg_small_chr = !sc;
            chr_bank0 = 5'b11100;
            @(negedge clk);
            chk("R1 a18", int'(prg_a18), lp ? 1 : 0);
            chk("R1 page", int'(ram_page), sc ? 3 : 0);
            chk("R1 en", int'(ram_en), (!lp && sc) ? 0 : 1);

            for (int i = 0; i < 400; i++)
                step(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
                     ($urandom % 4) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule